// File: doc/BRIEF.md
# Complementary Gate Pair Generator

This block produces one pair of non-overlapping gate-drive signals, a high-side output and a low-side output, for each of several phases. Every phase has its own period counter. A fixed set of equality compares against that counter moves the pair through four switching points, with a guard interval of DEAD clock cycles between one output turning off and the other turning on. The block runs from a 50 MHz system clock.

All phases share a period setting. Each phase has its own half-duty setting. Both settings are sampled only at the edge where the phase counter wraps to zero. A value written in the middle of a period therefore cannot move a switching point that has already been passed, and it cannot cause a stray pulse. A half-duty of roughly a quarter of the period puts both outputs close to equal conduction. Legal settings satisfy 1 <= H and 2*(H+DEAD) < P, where H is the half-duty and P is the period.

Top module: `gate_pair_gen`

## Requirements
- R1: While rst_ni is low, every bit of hs_o and ls_o is 0.
- R2: On the first rising clock edge after rst_ni goes high, every hs_o bit goes to 1 and every ls_o bit stays 0. That edge starts period zero, with the phase count at 0.
- R3: Each phase count steps by one per clock from 0 to P-1 and then returns to 0, so the output pattern repeats every P cycles.
- R4: For a phase count value c, hs_o is low in the cycle after the edge where c equals H, and it goes high again after the edge where c equals P-H. Equivalently, hs_o is 0 exactly when the current count lies in H+1 to P-H.
- R5: ls_o goes high after the edge where c equals H+DEAD, and it goes low after the edge where c equals P-H-DEAD. Equivalently, ls_o is 1 exactly when the count lies in H+DEAD+1 to P-H-DEAD.
- R6: Phase i takes its half-duty from half_i[i*CNT_W +: CNT_W]. Phases with different half-duty values produce different pulse widths at the same time.
- R7: A change on half_i or period_i has no effect on the outputs until the next wrap edge of the phase count. From that edge onward, the value present on the inputs at that edge is used for the whole period.
- R8: For each phase, hs_o and ls_o are never 1 in the same cycle.
- R9: For each phase, at least DEAD cycles (DEAD = 10) pass between one output of the pair going low and the other going high. The two outputs never change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | CNT_W | Period length P in clock cycles, shared by all phases |
| half_i | input | NUM_PH*CNT_W | Half-duty H for each phase, one CNT_W field per phase |
| hs_o | output | NUM_PH | High-side drive, one bit per phase |
| ls_o | output | NUM_PH | Low-side drive, one bit per phase |

## Verification
The period wrap and a settings update can fall on the same clock edge. In that case, a new half-duty is presented in the cycle just before the wrap edge and must be used for the whole of the following period. The bench provokes this in two ways. It changes half_i mid-period and again on the last count of a period, then compares every sampled output against a closed-form pattern that switches to the new half-duty exactly at the period boundary. A random stress run changes both settings at arbitrary cycles, including wrap cycles, and judges the pair only on overlap and on guard-interval length.

// File: rtl/gate_pair_pkg.sv
package gate_pair_pkg;
  // switching action picked for the current count, in priority order
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_HS_OFF,
    ACT_LS_ON,
    ACT_LS_OFF,
    ACT_HS_ON
  } sw_act_e;
endpackage

// File: rtl/gp_phase_cnt.sv
module gp_phase_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] half_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] half_o
);
  logic [CNT_W-1:0] cnt_q, per_q, half_q;
  logic             wrap;

  assign wrap = (cnt_q >= per_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      per_q  <= '0;
      half_q <= '0;
    end else if (start_i) begin
      cnt_q  <= '0;
      per_q  <= per_i;
      half_q <= half_i;
    end else if (wrap) begin
      // settings are taken only here
      cnt_q  <= '0;
      per_q  <= per_i;
      half_q <= half_i;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign per_o  = per_q;
  assign half_o = half_q;
endmodule

// File: rtl/gp_edge_dec.sv
module gp_edge_dec
  import gate_pair_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int DEAD  = 10
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] half_i,
  output sw_act_e          act_o
);
  localparam logic [CNT_W-1:0] DeadC = CNT_W'(DEAD);

  logic [CNT_W-1:0] pt_hs_off, pt_ls_on, pt_ls_off, pt_hs_on;

  assign pt_hs_off = half_i;
  assign pt_ls_on  = half_i + DeadC;
  assign pt_hs_on  = per_i - half_i;
  assign pt_ls_off = per_i - half_i - DeadC;

  always_comb begin
    if (cnt_i == pt_hs_off)      act_o = ACT_HS_OFF;
    else if (cnt_i == pt_ls_on)  act_o = ACT_LS_ON;
    else if (cnt_i == pt_ls_off) act_o = ACT_LS_OFF;
    else if (cnt_i == pt_hs_on)  act_o = ACT_HS_ON;
    else                         act_o = ACT_NONE;
  end
endmodule

// File: rtl/gp_drive.sv
module gp_drive
  import gate_pair_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  sw_act_e act_i,
  output logic    hs_o,
  output logic    ls_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_o <= 1'b0;
      ls_o <= 1'b0;
    end else if (start_i) begin
      hs_o <= 1'b1;
      ls_o <= 1'b0;
    end else begin
      unique case (act_i)
        ACT_HS_OFF: hs_o <= 1'b0;
        ACT_LS_ON:  ls_o <= 1'b1;
        ACT_LS_OFF: ls_o <= 1'b0;
        ACT_HS_ON:  hs_o <= 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/gate_pair_gen.sv
module gate_pair_gen
  import gate_pair_pkg::*;
#(
  parameter int NUM_PH = 2,
  parameter int CNT_W  = 12,
  parameter int DEAD   = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CNT_W-1:0]        period_i,
  input  logic [NUM_PH*CNT_W-1:0] half_i,
  output logic [NUM_PH-1:0]       hs_o,
  output logic [NUM_PH-1:0]       ls_o
);
  logic run_q;
  logic start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  assign start = !run_q;

  for (genvar i = 0; i < NUM_PH; i++) begin : g_ph
    logic [CNT_W-1:0] cnt, per_act, half_act;
    sw_act_e          act;

    gp_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start),
      .per_i   (period_i),
      .half_i  (half_i[i*CNT_W +: CNT_W]),
      .cnt_o   (cnt),
      .per_o   (per_act),
      .half_o  (half_act)
    );

    gp_edge_dec #(.CNT_W(CNT_W), .DEAD(DEAD)) u_dec (
      .cnt_i  (cnt),
      .per_i  (per_act),
      .half_i (half_act),
      .act_o  (act)
    );

    gp_drive u_drv (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start),
      .act_i   (act),
      .hs_o    (hs_o[i]),
      .ls_o    (ls_o[i])
    );
  end
endmodule

// File: rtl/gate_pair_chk.sv
module gate_pair_chk #(
  parameter int NUM_PH = 2,
  parameter int DEAD   = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_PH-1:0] hs_i,
  input logic [NUM_PH-1:0] ls_i
);
  logic first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) first_q <= 1'b1;
    else         first_q <= 1'b0;
  end

  for (genvar i = 0; i < NUM_PH; i++) begin : g_ph
    logic [7:0] hs_lo_q, ls_lo_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hs_lo_q <= 8'hff;
        ls_lo_q <= 8'hff;
      end else begin
        hs_lo_q <= hs_i[i] ? 8'd0 : ((hs_lo_q == 8'hff) ? hs_lo_q : hs_lo_q + 8'd1);
        ls_lo_q <= ls_i[i] ? 8'd0 : ((ls_lo_q == 8'hff) ? ls_lo_q : ls_lo_q + 8'd1);
      end
    end

    // R2
    start_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      first_q |=> (hs_i[i] && !ls_i[i]));

    // R8
    no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hs_i[i] && ls_i[i]));

    // R9
    ls_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ls_i[i]) |-> (hs_lo_q >= 8'(DEAD)));

    // R9
    hs_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hs_i[i]) |-> (ls_lo_q >= 8'(DEAD)));

    // R9
    single_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(!$stable(hs_i[i]) && !$stable(ls_i[i])));
  end
endmodule

bind gate_pair_gen gate_pair_chk #(.NUM_PH(NUM_PH), .DEAD(DEAD)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .hs_i   (hs_o),
  .ls_i   (ls_o)
);

// File: tb/gate_pair_gen_bench.sv
module gate_pair_gen_bench;
  localparam int NUM_PH = 2;
  localparam int CNT_W  = 12;
  localparam int DEAD   = 10;
  localparam int NVEC   = 5;

  // {period, half phase0, half phase1}
  localparam logic [3*CNT_W-1:0] VEC [NVEC] = '{
    {12'd100, 12'd25, 12'd30},
    {12'd64,  12'd5,  12'd12},
    {12'd200, 12'd50, 12'd80},
    {12'd48,  12'd1,  12'd13},
    {12'd150, 12'd40, 12'd2}
  };

  logic                    clk = 1'b0;
  logic                    rst_ni = 1'b0;
  logic [CNT_W-1:0]        period_i = '0;
  logic [NUM_PH*CNT_W-1:0] half_i = '0;
  logic [NUM_PH-1:0]       hs_o, ls_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  gate_pair_gen #(.NUM_PH(NUM_PH), .CNT_W(CNT_W), .DEAD(DEAD)) u_gate_pair_gen (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .period_i (period_i),
    .half_i   (half_i),
    .hs_o     (hs_o),
    .ls_o     (ls_o)
  );

  function automatic logic exp_hs(int n, int p, int h);
    int c = n % p;
    return !((c >= h + 1) && (c <= p - h));
  endfunction

  function automatic logic exp_ls(int n, int p, int h);
    int c = n % p;
    return (c >= h + DEAD + 1) && (c <= p - h - DEAD);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic do_reset(int p, int h0, int h1);
    @(negedge clk);
    rst_ni = 1'b0;
    period_i = CNT_W'(p);
    half_i = {CNT_W'(h1), CNT_W'(h0)};
    repeat (3) @(negedge clk);
    chk("R1", "hs in reset", int'(hs_o), 0);
    chk("R1", "ls in reset", int'(ls_o), 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // table walk: R2..R6 against closed-form pattern
    for (int v = 0; v < NVEC; v++) begin
      int p  = int'(VEC[v][3*CNT_W-1 -: CNT_W]);
      int h0 = int'(VEC[v][2*CNT_W-1 -: CNT_W]);
      int h1 = int'(VEC[v][CNT_W-1:0]);
      do_reset(p, h0, h1);
      for (int n = 0; n < 3 * p; n++) begin
        string rq;
        @(negedge clk);
        rq = (n == 0) ? "R2" : ((n % p == 0) ? "R3" : "R4");
        chk(rq, "hs ph0", int'(hs_o[0]), int'(exp_hs(n, p, h0)));
        chk((n == 0) ? "R2" : "R5", "ls ph0", int'(ls_o[0]), int'(exp_ls(n, p, h0)));
        chk("R6", "hs ph1", int'(hs_o[1]), int'(exp_hs(n, p, h1)));
        chk("R6", "ls ph1", int'(ls_o[1]), int'(exp_ls(n, p, h1)));
      end
    end

    // R7: mid-period change, then change on the last count before wrap
    begin
      int p = 100;
      do_reset(p, 20, 20);
      for (int n = 0; n < 4 * p; n++) begin
        int hk;
        @(negedge clk);
        hk = (n < p) ? 20 : ((n < 2 * p) ? 35 : 10);
        chk("R7", "hs after update", int'(hs_o[0]), int'(exp_hs(n, p, hk)));
        chk("R7", "ls after update", int'(ls_o[0]), int'(exp_ls(n, p, hk)));
        if (n == 30)        half_i = {CNT_W'(35), CNT_W'(35)};
        if (n == 2 * p - 1) half_i = {CNT_W'(10), CNT_W'(10)};
      end
    end

    // R8 R9: random settings at random cycles
    begin
      int hs_run [NUM_PH];
      int ls_run [NUM_PH];
      logic [NUM_PH-1:0] hs_prev, ls_prev;
      do_reset(150, 30, 30);
      for (int k = 0; k < NUM_PH; k++) begin
        hs_run[k] = 1000;
        ls_run[k] = 1000;
      end
      hs_prev = '0;
      ls_prev = '0;
      for (int n = 0; n < 6000; n++) begin
        @(negedge clk);
        for (int k = 0; k < NUM_PH; k++) begin
          chk("R8", "overlap", int'(hs_o[k] && ls_o[k]), 0);
          if (ls_o[k] && !ls_prev[k])
            chk("R9", "guard before ls", int'(hs_run[k] >= DEAD), 1);
          if (hs_o[k] && !hs_prev[k] && n > 0)
            chk("R9", "guard before hs", int'(ls_run[k] >= DEAD), 1);
          hs_run[k] = hs_o[k] ? 0 : hs_run[k] + 1;
          ls_run[k] = ls_o[k] ? 0 : ls_run[k] + 1;
        end
        hs_prev = hs_o;
        ls_prev = ls_o;
        if ($urandom_range(39) == 0)
          half_i[CNT_W-1:0] = CNT_W'($urandom_range(49, 1));
        if ($urandom_range(39) == 0)
          half_i[2*CNT_W-1:CNT_W] = CNT_W'($urandom_range(49, 1));
        if ($urandom_range(99) == 0)
          period_i = CNT_W'($urandom_range(200, 120));
      end
    end

    finish_run();
  end
endmodule